// File: doc/BRIEF.md
# Privileged Fence and Wait Legality Checker

This block sits beside the execute stage of a core that has a hypervisor extension. For each instruction it is offered, it decides whether the instruction may run, given the current privilege, the virtualization flag and three trap-control bits. The instruction is one of four kinds:

- wait-for-interrupt
- supervisor translation fence
- guest-virtual hypervisor fence
- guest-physical hypervisor fence

Exactly one verdict comes out, one cycle after the request. The verdict is one of:

- a halt request
- a translation-cache flush pulse
- an exception carrying a cause code

An illegal-instruction fault and a virtual-instruction fault are reported separately, so the trap logic can route each to the right handler. The TLB itself and the wake-up from halt belong to other blocks.

Encodings used at the ports:

- `op_i`: 00 = wait, 01 = supervisor fence, 10 = guest-virtual hypervisor fence, 11 = guest-physical hypervisor fence.
- `priv_i`: 00 = user, 01 = supervisor, 11 = machine. The reserved value 10 is treated as user.

Top module: `priv_op_gate`

## Requirements
- R1: A wait (op 00) produces an exception with cause 22 when virt_i is 1, or when priv is supervisor (01) and tw_i is 1.
- R2: A wait in any other case produces a single halt_o pulse and no exception.
- R3: A supervisor fence (op 01) produces an exception with cause 2 when priv is user, or when priv is supervisor and tvm_i is 1.
- R4: A supervisor fence not covered by R3 produces cause 22 when virt_i and vtvm_i are both 1, and a flush_o pulse otherwise.
- R5: A hypervisor fence (op 10 or 11) in supervisor mode with virt_i set produces cause 22.
- R6: A hypervisor fence not covered by R5 or R7 flushes in machine mode or in supervisor mode with virt_i clear; in user mode it produces cause 2.
- R7: A guest-physical fence (op 11) in supervisor mode with virt_i clear and tvm_i set produces cause 2, ahead of R6.
- R8: The verdict appears on the outputs exactly one cycle after valid_i is sampled and lasts one cycle. At most one of halt_o, flush_o and excp_o is high in any cycle.
- R9: cause_o is 2 or 22 while excp_o is high, and 0 otherwise.
- R10: When valid_i is 0, the operation and control inputs have no effect: all outputs stay low the next cycle.
- R11: While rst_ni is low and after its release, all outputs are low until a request is taken.
- R12: The reserved privilege encoding 10 gives the same verdict as user mode (00) for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | A request is present this cycle |
| op_i | input | 2 | Operation kind (00 wait, 01 supervisor fence, 10 guest-virtual fence, 11 guest-physical fence) |
| priv_i | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine, 10 as user) |
| virt_i | input | 1 | Virtualization on |
| tw_i | input | 1 | Trap-wait control bit |
| tvm_i | input | 1 | Trap-translation control bit |
| vtvm_i | input | 1 | Trap-translation control bit for the guest |
| halt_o | output | 1 | Halt request pulse |
| flush_o | output | 1 | Translation-cache flush pulse |
| excp_o | output | 1 | Exception pulse |
| cause_o | output | CAUSE_W (6) | Exception cause code |

## Verification
The in-RTL assertions check, on every cycle, the properties that hold regardless of which rule applied:

- the three outputs are mutually exclusive;
- the cause code is legal and zero when there is no exception;
- an idle cycle leaves the next cycle quiet;
- only a wait halts, and a user-mode request never flushes.

Which of the two fault kinds each operation picks, and the ordering between the trap-control bits, can only be shown by the bench. It sweeps every combination of privilege, virtualization and control bits for each operation and compares the outcome with a model written from the requirements.

// File: rtl/priv_op_gate_pkg.sv
package priv_op_gate_pkg;

  typedef enum logic [1:0] {
    OP_WAIT   = 2'b00,
    OP_SFENCE = 2'b01,
    OP_HVVMA  = 2'b10,
    OP_HGVMA  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    LVL_U   = 2'b00,
    LVL_S   = 2'b01,
    LVL_RSV = 2'b10,
    LVL_M   = 2'b11
  } lvl_e;

  typedef enum logic [2:0] {
    V_NONE  = 3'd0,
    V_HALT  = 3'd1,
    V_FLUSH = 3'd2,
    V_ILL   = 3'd3,
    V_VIRT  = 3'd4
  } verdict_e;

  // reserved level folds onto user
  function automatic lvl_e fold_lvl(input logic [1:0] raw);
    return (raw == LVL_RSV) ? LVL_U : lvl_e'(raw);
  endfunction

endpackage

// File: rtl/pog_decode.sv
module pog_decode
  import priv_op_gate_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       tw_i,
  input  logic       tvm_i,
  input  logic       vtvm_i,
  output verdict_e   verdict_o
);

  lvl_e lvl;
  logic in_s, in_m, in_u;
  verdict_e v_wait, v_sfence, v_hfence, v_hgvma;

  assign lvl  = fold_lvl(priv_i);
  assign in_s = (lvl == LVL_S);
  assign in_m = (lvl == LVL_M);
  assign in_u = (lvl == LVL_U);

  always_comb begin
    if ((in_s && tw_i) || virt_i) v_wait = V_VIRT;
    else                          v_wait = V_HALT;
  end

  always_comb begin
    if (in_u || (in_s && tvm_i)) v_sfence = V_ILL;
    else if (virt_i && vtvm_i)   v_sfence = V_VIRT;
    else                         v_sfence = V_FLUSH;
  end

  always_comb begin
    if (in_s && virt_i)               v_hfence = V_VIRT;
    else if (in_m || (in_s && !virt_i)) v_hfence = V_FLUSH;
    else                              v_hfence = V_ILL;
  end

  // guest-physical fence: TVM check ranks first
  always_comb begin
    if (in_s && !virt_i && tvm_i) v_hgvma = V_ILL;
    else                          v_hgvma = v_hfence;
  end

  always_comb begin
    unique case (op_e'(op_i))
      OP_WAIT:   verdict_o = v_wait;
      OP_SFENCE: verdict_o = v_sfence;
      OP_HVVMA:  verdict_o = v_hfence;
      default:   verdict_o = v_hgvma;
    endcase
  end

endmodule

// File: rtl/pog_out_reg.sv
module pog_out_reg
  import priv_op_gate_pkg::*;
#(
  parameter int unsigned CAUSE_W   = 6,
  parameter int unsigned ILL_CODE  = 2,
  parameter int unsigned VIRT_CODE = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  verdict_e           verdict_i,
  output logic               halt_o,
  output logic               flush_o,
  output logic               excp_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam logic [CAUSE_W-1:0] ILL_C  = CAUSE_W'(ILL_CODE);
  localparam logic [CAUSE_W-1:0] VIRT_C = CAUSE_W'(VIRT_CODE);

  verdict_e           v_eff;
  logic [CAUSE_W-1:0] cause_d;

  assign v_eff = valid_i ? verdict_i : V_NONE;

  always_comb begin
    unique case (v_eff)
      V_ILL:   cause_d = ILL_C;
      V_VIRT:  cause_d = VIRT_C;
      default: cause_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o  <= 1'b0;
      flush_o <= 1'b0;
      excp_o  <= 1'b0;
      cause_o <= '0;
    end else begin
      halt_o  <= (v_eff == V_HALT);
      flush_o <= (v_eff == V_FLUSH);
      excp_o  <= (v_eff == V_ILL) || (v_eff == V_VIRT);
      cause_o <= cause_d;
    end
  end

  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({halt_o, flush_o, excp_o})); // R8

  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excp_o |-> (cause_o == ILL_C || cause_o == VIRT_C)); // R9

  AST_CAUSE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !excp_o |-> (cause_o == '0)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(halt_o || flush_o || excp_o)); // R10

endmodule

// File: rtl/priv_op_gate.sv
module priv_op_gate
  import priv_op_gate_pkg::*;
#(
  parameter int unsigned CAUSE_W   = 6,
  parameter int unsigned ILL_CODE  = 2,
  parameter int unsigned VIRT_CODE = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [1:0]         op_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               tw_i,
  input  logic               tvm_i,
  input  logic               vtvm_i,
  output logic               halt_o,
  output logic               flush_o,
  output logic               excp_o,
  output logic [CAUSE_W-1:0] cause_o
);

  verdict_e verdict;

  pog_decode u_decode (
    .op_i      (op_i),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .tw_i      (tw_i),
    .tvm_i     (tvm_i),
    .vtvm_i    (vtvm_i),
    .verdict_o (verdict)
  );

  pog_out_reg #(
    .CAUSE_W   (CAUSE_W),
    .ILL_CODE  (ILL_CODE),
    .VIRT_CODE (VIRT_CODE)
  ) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .verdict_i (verdict),
    .halt_o    (halt_o),
    .flush_o   (flush_o),
    .excp_o    (excp_o),
    .cause_o   (cause_o)
  );

  AST_HALT_ONLY_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> ($past(op_i) == OP_WAIT)); // R2

  AST_USER_NO_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> ($past(priv_i) == LVL_S || $past(priv_i) == LVL_M)); // R6

endmodule

// File: tb/priv_op_gate_tb_top.sv
`timescale 1ns/1ps
module priv_op_gate_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = '0, priv_i = '0;
  logic       virt_i = 0, tw_i = 0, tvm_i = 0, vtvm_i = 0;
  logic       halt_o, flush_o, excp_o;
  logic [5:0] cause_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  priv_op_gate dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .priv_i(priv_i), .virt_i(virt_i), .tw_i(tw_i), .tvm_i(tvm_i),
    .vtvm_i(vtvm_i), .halt_o(halt_o), .flush_o(flush_o),
    .excp_o(excp_o), .cause_o(cause_o)
  );

  // packed expectation {halt, flush, excp, cause[5:0]}
  localparam logic [8:0] E_NONE  = 9'b000_000000;
  localparam logic [8:0] E_HALT  = 9'b100_000000;
  localparam logic [8:0] E_FLUSH = 9'b010_000000;
  localparam logic [8:0] E_ILL   = {3'b001, 6'd2};
  localparam logic [8:0] E_VIRT  = {3'b001, 6'd22};

  function automatic logic [8:0] model(input logic [1:0] op, input logic [1:0] pr,
                                       input logic v, input logic tw,
                                       input logic tvm, input logic vtvm);
    logic s, m, u;
    logic [1:0] p;
    p = (pr == 2'b10) ? 2'b00 : pr;
    s = (p == 2'b01); m = (p == 2'b11); u = (p == 2'b00);
    case (op)
      2'b00: return ((s && tw) || v) ? E_VIRT : E_HALT;
      2'b01: begin
        if (u || (s && tvm)) return E_ILL;
        if (v && vtvm) return E_VIRT;
        return E_FLUSH;
      end
      default: begin
        if (op == 2'b11 && s && !v && tvm) return E_ILL;
        if (s && v) return E_VIRT;
        if (m || (s && !v)) return E_FLUSH;
        return E_ILL;
      end
    endcase
  endfunction

  function automatic logic [8:0] outs();
    return {halt_o, flush_o, excp_o, cause_o};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one request: verdict one cycle later, quiet the cycle after
  task automatic issue(input string req, input logic [1:0] op, input logic [1:0] pr,
                       input logic v, input logic tw, input logic tvm, input logic vtvm);
    @(negedge clk_i);
    valid_i = 1; op_i = op; priv_i = pr; virt_i = v; tw_i = tw; tvm_i = tvm; vtvm_i = vtvm;
    @(negedge clk_i);
    valid_i = 0;
    check(req, outs(), model(op, pr, v, tw, tvm, vtvm));
    @(negedge clk_i);
    check("R8", outs(), E_NONE);
  endtask

  task automatic sweep(input string req, input logic [1:0] op);
    for (int i = 0; i < 64; i++)
      issue(req, op, i[1:0], i[2], i[3], i[4], i[5]);
  endtask

  task automatic t_reset();
    rst_ni = 0;
    #23;
    check("R11", outs(), E_NONE);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    check("R11", outs(), E_NONE);
  endtask

  task automatic t_corners();
    issue("R1", 2'b00, 2'b01, 0, 1, 0, 0);
    check("R1", E_VIRT, model(2'b00, 2'b01, 0, 1, 0, 0));
    issue("R2", 2'b00, 2'b00, 0, 1, 1, 1);
    issue("R3", 2'b01, 2'b01, 1, 0, 1, 1);
    issue("R4", 2'b01, 2'b11, 1, 0, 0, 1);
    issue("R5", 2'b10, 2'b01, 1, 0, 0, 0);
    issue("R6", 2'b10, 2'b00, 0, 0, 0, 0);
    issue("R7", 2'b11, 2'b01, 0, 0, 1, 0);
    issue("R9", 2'b11, 2'b11, 1, 0, 1, 1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk_i);
    valid_i = 1; op_i = 2'b01; priv_i = 2'b11; virt_i = 0; tw_i = 0; tvm_i = 0; vtvm_i = 0;
    @(negedge clk_i);
    check("R8", outs(), E_FLUSH);
    op_i = 2'b00; priv_i = 2'b11;
    @(negedge clk_i);
    valid_i = 0;
    check("R8", outs(), E_HALT);
    @(negedge clk_i);
    check("R8", outs(), E_NONE);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      valid_i = 0; op_i = i[1:0]; priv_i = i[3:2]; virt_i = i[0]; tw_i = i[1];
      tvm_i = i[2]; vtvm_i = i[3];
      @(negedge clk_i);
      check("R10", outs(), E_NONE);
    end
  endtask

  task automatic t_reserved();
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 16; i++) begin
        issue("R12", op[1:0], 2'b10, i[0], i[1], i[2], i[3]);
        check("R12", model(op[1:0], 2'b10, i[0], i[1], i[2], i[3]),
              model(op[1:0], 2'b00, i[0], i[1], i[2], i[3]));
      end
  endtask

  initial begin
    t_reset();
    t_corners();
    sweep("R1_R2", 2'b00);
    sweep("R3_R4", 2'b01);
    sweep("R5_R6", 2'b10);
    sweep("R7", 2'b11);
    t_back_to_back();
    t_idle();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule